// File: doc/BRIEF.md
# Normalized Taylor exponential unit

This block evaluates e^x in fixed point for the diode term of a photovoltaic cell model, where x is the diode voltage over the thermal voltage and can reach about 28. A direct series at that size would need far too many terms. The block instead divides x by 32 with an exact shift, so the reduced argument lies in [-1, 1). It then evaluates a degree-six Taylor polynomial on the reduced argument in Horner form, and restores the full exponential by squaring the polynomial result five times.

A single multiplier is shared across all eleven multiply steps. A small controller issues exactly one multiply per cycle, so the latency from acceptance to result is fixed. Requests arrive on a valid/ready pair carrying a signed argument. The result comes back as a one-cycle valid pulse with the value and an overflow flag. The unit accepts one request at a time, and it can take a new request only after the previous result has been shown for its cycle.

Top module: `ntaylor_exp`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is then high for exactly one cycle, in the cycle that follows the 11th rising edge after the accepting edge.
- R3: `in_ready` is 1 only while the unit is idle. It is 0 from the edge after acceptance through the cycle in which `out_valid` is high, and it returns to 1 in the next cycle.
- R4: The result is bit-exact to the following procedure. The argument `in_arg` is signed Q5.10. It is converted to the working format (signed, 24 fractional bits) and divided by 32, which is exact, giving r. The accumulator starts at c6. For k = 5 down to 0, it becomes c_k + floor(r*acc / 2^24), where c_k = round(2^24 / k!). The accumulator is then squared five times as unsigned values: floor(acc*acc / 2^24). `out_result` is unsigned with 24 fractional bits.
- R5: An argument of 0 gives `out_result` = 2^24 (exactly 1.0) with `out_ovf` = 0.
- R6: If any squaring produces a value of 2^64 or more, `out_ovf` is 1 and `out_result` is all ones (full scale). For example, an argument of 28.0 (raw 28672) overflows.
- R7: For arguments from 0 to 26.0 the result is within 2% + 4 LSB of the true e^x.
- R8: Negative arguments are accepted. For any negative argument the result is at most 2^24 (1.0) and `out_ovf` is 0.
- R9: `in_arg` is sampled only at acceptance. Values presented while the unit is busy, even with `in_valid` held high, do not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to accept |
| in_arg | input | ARG_W (16) | Signed argument, ARG_FRAC (10) fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | DATA_W (64) | Unsigned e^x, FRAC (24) fractional bits |
| out_ovf | output | 1 | Saturation occurred during squaring |

## Verification
Each result is due in the cycle after the 11th rising edge that follows the accepting edge, and `in_ready` comes back one cycle after that. The bench's reference model counts down on every rising edge from the acceptance it observes. Outputs are compared against the model at every falling edge, so a result that arrives one cycle early or late fails on `out_valid` in that cycle. The value is checked in the strobe cycle against the bench's own wide-integer evaluation, and positive arguments are also checked against a real-valued exponential.

// File: rtl/ntexp_pkg.sv
package ntexp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLY = 2'd1,
    ST_SQR  = 2'd2,
    ST_OUT  = 2'd3
  } ntexp_state_e;

  // round(2^frac / k!) as an unsigned 64-bit value
  function automatic longint unsigned recip_fact_q(input int k, input int frac);
    longint unsigned fct;
    longint unsigned one;
    fct = 64'd1;
    for (int i = 2; i <= k; i++) fct = fct * longint'(i);
    one = 64'd1 << frac;
    return (one + fct / 64'd2) / fct;
  endfunction

endpackage

// File: rtl/ntexp_coef.sv
module ntexp_coef #(
  parameter int TERMS  = 6,
  parameter int DATA_W = 64,
  parameter int FRAC   = 24,
  localparam int IDX_W = $clog2(TERMS + 1)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] coef
);
  import ntexp_pkg::*;

  logic [DATA_W-1:0] tbl [0:TERMS];

  for (genvar k = 0; k <= TERMS; k++) begin : g_coef
    assign tbl[k] = DATA_W'(recip_fact_q(k, FRAC));
  end

  always_comb begin
    coef = tbl[TERMS];
    for (int k = 0; k <= TERMS; k++) begin
      if (idx == IDX_W'(k)) coef = tbl[k];
    end
  end
endmodule

// File: rtl/ntexp_mul.sv
module ntexp_mul #(
  parameter int DATA_W = 64,
  parameter int FRAC   = 24
) (
  input  logic              sq_mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] prod,
  output logic              prod_ovf
);
  localparam int EW = DATA_W + 1;
  localparam int PW = 2 * EW;

  logic signed [EW-1:0] a_x, b_x;
  logic signed [PW-1:0] full, scaled;

  // signed operands in the polynomial phase, unsigned when squaring
  assign a_x = sq_mode ? $signed({1'b0, op_a}) : $signed({op_a[DATA_W-1], op_a});
  assign b_x = sq_mode ? $signed({1'b0, op_b}) : $signed({op_b[DATA_W-1], op_b});

  assign full     = a_x * b_x;
  assign scaled   = full >>> FRAC;
  assign prod     = scaled[DATA_W-1:0];
  assign prod_ovf = sq_mode && (|scaled[PW-1:DATA_W]);
endmodule

// File: rtl/ntexp_ctrl.sv
module ntexp_ctrl #(
  parameter int TERMS     = 6,
  parameter int SQUARINGS = 5,
  localparam int STEP_W   = $clog2(TERMS + SQUARINGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              accept,
  output logic              poly_en,
  output logic              sqr_en,
  output logic              out_valid,
  output logic [STEP_W-1:0] step
);
  import ntexp_pkg::*;

  ntexp_state_e state;
  logic         poly_last, sqr_last;

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign poly_en   = (state == ST_POLY);
  assign sqr_en    = (state == ST_SQR);
  assign out_valid = (state == ST_OUT);
  assign poly_last = poly_en && (step == STEP_W'(TERMS - 1));
  assign sqr_last  = sqr_en && (step == STEP_W'(SQUARINGS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_POLY;
          step  <= '0;
        end
        ST_POLY: if (poly_last) begin
          state <= ST_SQR;
          step  <= '0;
        end else begin
          step <= step + 1'b1;
        end
        ST_SQR: if (sqr_last) begin
          state <= ST_OUT;
          step  <= '0;
        end else begin
          step <= step + 1'b1;
        end
        ST_OUT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_ready_after_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    poly_en |-> step < STEP_W'(TERMS));
  p_sqr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sqr_en |-> step < STEP_W'(SQUARINGS));
endmodule

// File: rtl/ntaylor_exp.sv
module ntaylor_exp #(
  parameter int ARG_W     = 16,
  parameter int ARG_FRAC  = 10,
  parameter int DATA_W    = 64,
  parameter int FRAC      = 24,
  parameter int TERMS     = 6,
  parameter int SQUARINGS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ARG_W-1:0]  in_arg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_ovf
);
  localparam int RED_SHIFT = FRAC - ARG_FRAC - SQUARINGS;
  localparam int LATENCY   = TERMS + SQUARINGS;
  localparam int IDX_W     = $clog2(TERMS + 1);
  localparam int STEP_W    = $clog2(TERMS + SQUARINGS + 1);
  localparam int CNT_W     = $clog2(LATENCY + 2) + 1;
  localparam logic [DATA_W-1:0] ONE_Q = DATA_W'(1) << FRAC;

  logic              accept, poly_en, sqr_en;
  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  coef_idx;
  logic [DATA_W-1:0] coef, prod, op_a, red_arg;
  logic              prod_ovf;
  logic [DATA_W-1:0] acc, red_q;
  logic              ovf_q;

  ntexp_ctrl #(.TERMS(TERMS), .SQUARINGS(SQUARINGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .poly_en(poly_en), .sqr_en(sqr_en),
    .out_valid(out_valid), .step(step)
  );

  // coefficient for the current Horner stage; top coefficient when idle
  assign coef_idx = poly_en ? (IDX_W'(TERMS - 1) - IDX_W'(step)) : IDX_W'(TERMS);

  ntexp_coef #(.TERMS(TERMS), .DATA_W(DATA_W), .FRAC(FRAC)) u_coef (
    .idx(coef_idx), .coef(coef)
  );

  assign op_a = sqr_en ? acc : red_q;

  ntexp_mul #(.DATA_W(DATA_W), .FRAC(FRAC)) u_mul (
    .sq_mode(sqr_en), .op_a(op_a), .op_b(acc), .prod(prod), .prod_ovf(prod_ovf)
  );

  // sign-extend and move to the working scale; the divide by 2^SQUARINGS is folded in
  assign red_arg = {{(DATA_W - ARG_W){in_arg[ARG_W-1]}}, in_arg} << RED_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      red_q <= '0;
      ovf_q <= 1'b0;
    end else if (accept) begin
      red_q <= red_arg;
      acc   <= coef;
      ovf_q <= 1'b0;
    end else if (poly_en) begin
      acc <= coef + prod;
    end else if (sqr_en) begin
      acc   <= prod_ovf ? '1 : prod;
      ovf_q <= ovf_q | prod_ovf;
    end
  end

  assign out_result = acc;
  assign out_ovf    = ovf_q;

  // ---------------- checker state and assertions ----------------
  logic             zero_q, neg_q;
  logic [CNT_W-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q  <= 1'b0;
      neg_q   <= 1'b0;
      lat_cnt <= '0;
    end else begin
      if (accept) begin
        zero_q  <= (in_arg == '0);
        neg_q   <= in_arg[ARG_W-1];
        lat_cnt <= CNT_W'(1);
      end else if (out_valid) begin
        lat_cnt <= '0;
      end else if (lat_cnt != '0) begin
        lat_cnt <= lat_cnt + 1'b1;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lat_cnt == CNT_W'(LATENCY + 1));
  p_zero_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zero_q) |-> (out_result == ONE_Q && !out_ovf));
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (&out_result));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sqr_en && prod_ovf) |=> ovf_q);
  p_negative_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && neg_q) |-> (out_result <= ONE_Q && !out_ovf));
  p_horner_positive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poly_en |-> (!acc[DATA_W-1] && acc != '0));
endmodule

// File: tb/ntaylor_exp_bench.sv
module ntaylor_exp_bench;
  localparam int LAT = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_arg = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_ovf;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  bit          m_ready = 1'b1;
  bit          m_valid = 1'b0;
  int          m_cd    = 0;
  logic [63:0] m_res;
  bit          m_ovf;
  logic [15:0] m_arg;
  string       cur_tag = "R4";
  string       m_tag;
  bit          cur_approx = 1'b0;
  bit          m_approx;

  always #2 clk = ~clk;

  ntaylor_exp u_ntaylor_exp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_arg(in_arg), .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [131:0] recip(input int k);
    longint f = 1;
    for (int i = 1; i <= k; i++) f = f * i;
    return 132'((((64'd1 << 25) / f) + 1) / 2);
  endfunction

  // wide-integer statement of R4
  task automatic ref_exp(input logic [15:0] a, output logic [63:0] res, output bit ovf);
    logic signed [131:0] r, p, t;
    r = $signed(a);
    r = r * 512;
    p = recip(6);
    for (int k = 5; k >= 0; k--) begin
      t = r * p;
      p = (t >>> 24) + recip(k);
    end
    ovf = 1'b0;
    for (int s = 0; s < 5; s++) begin
      t = (p * p) >>> 24;
      if (ovf || t >= (132'sd1 <<< 64)) begin
        ovf = 1'b1;
        p = 132'({64{1'b1}});
      end else begin
        p = t;
      end
    end
    res = p[63:0];
  endtask

  task automatic tick(input bit v, input logic [15:0] a);
    in_valid = v;
    in_arg   = a;
    @(posedge clk);
    if (m_valid) begin
      m_valid = 1'b0;
      m_ready = 1'b1;
    end else if (m_cd > 0) begin
      m_cd--;
      if (m_cd == 0) m_valid = 1'b1;
    end else if (m_ready && v) begin
      m_ready  = 1'b0;
      m_cd     = LAT;
      m_arg    = a;
      m_tag    = cur_tag;
      m_approx = cur_approx;
      ref_exp(a, m_res, m_ovf);
    end
    @(negedge clk);
    chk(in_ready == m_ready, "R3", "in_ready", longint'(in_ready), longint'(m_ready));
    chk(out_valid == m_valid, "R2", "out_valid", longint'(out_valid), longint'(m_valid));
    if (m_valid && out_valid) begin
      chk(out_result == m_res, m_tag, "result", longint'(out_result), longint'(m_res));
      chk(out_ovf == m_ovf, m_tag, "ovf", longint'(out_ovf), longint'(m_ovf));
      if (m_ovf)
        chk(&out_result, "R6", "saturated result", longint'(out_result), -1);
      if (m_arg[15]) begin
        chk(out_result <= 64'd16777216, "R8", "negative arg result", longint'(out_result), 16777216);
        chk(!out_ovf, "R8", "negative arg ovf", longint'(out_ovf), 0);
      end
      if (m_approx && !m_ovf) begin
        real ideal, got;
        ideal = $exp(real'(int'($signed(m_arg))) / 1024.0);
        got   = real'(out_result) / 16777216.0;
        chk((got - ideal <= 0.02 * ideal + 4.0 / 16777216.0) &&
            (ideal - got <= 0.02 * ideal + 4.0 / 16777216.0),
            "R7", "accuracy", longint'(out_result), longint'(ideal * 16777216.0));
      end
    end
  endtask

  task automatic run_one(input logic [15:0] a, input string tag, input bit approx);
    cur_tag    = tag;
    cur_approx = approx;
    tick(1'b1, a);
    for (int i = 0; i < LAT + 1; i++) tick(1'b0, 16'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: state under reset and just after
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

    run_one(16'd0, "R5", 1'b1);                 // exactly 1.0
    run_one(16'd1024, "R4", 1'b1);              // 1.0
    run_one(16'd512, "R4", 1'b1);               // 0.5
    run_one(16'd5120, "R7", 1'b1);              // 5.0
    run_one(16'd20480, "R7", 1'b1);             // 20.0
    run_one(16'd26624, "R7", 1'b1);             // 26.0
    run_one(-16'sd1024, "R8", 1'b0);            // -1.0
    run_one(-16'sd10240, "R8", 1'b0);           // -10.0
    run_one(16'h8000, "R8", 1'b0);              // -32.0
    run_one(16'd28672, "R6", 1'b0);             // 28.0 overflows
    run_one(16'h7FFF, "R6", 1'b0);              // largest positive

    // R9: in_valid held high with changing data while busy
    cur_tag = "R9";
    cur_approx = 1'b1;
    tick(1'b1, 16'd2048);
    for (int i = 0; i < LAT + 1; i++) tick(1'b1, 16'd7000 + 16'(i * 300));
    cur_approx = 1'b0;
    for (int i = 0; i < LAT + 2; i++) tick(1'b0, 16'h0);

    // R4 spread of arguments
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_one(lfsr, "R4", (!lfsr[15] && lfsr <= 16'd26624));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule